// File: doc/BRIEF.md
# Disk Elevator Request Scheduler

This block keeps a small pool of pending disk requests, each a cylinder number, and decides which one the head serves next. Three policies are available, chosen by a mode input: plain arrival order, a bidirectional sweep that reverses at the last pending request in its direction, and a one-way upward sweep that wraps back to the lowest pending cylinder.

Requests enter through a valid/ready push port. When no grant is outstanding and at least one request is pending, the block searches the pool and registers the winning cylinder on the grant output. The grant is held until the consumer pulses done; that retires the entry, moves the head to the granted cylinder and adds the distance travelled to a running movement total. The next grant is selected on the cycle after a retirement.

Top module: `disk_elevator_sched`

## Requirements
- R1: After reset no grant is valid, push ready is high, the head equals the HEAD_INIT parameter, the direction flag is 1 (upward) and the movement total is 0.
- R2: A push is accepted on a clock edge where req_valid_i and req_ready_o are both high; req_ready_o is low exactly when DEPTH requests are pending, and a push offered while it is low is dropped.
- R3: grant_valid_o rises one cycle after a cycle with no grant and at least one pending request; it is never high with an empty pool; the granted cylinder stays unchanged until done_i, and done_i without a valid grant has no effect.
- R4: With mode_i = 0 grants follow arrival order; from head 53 the sequence 98, 183, 37, 122, 14, 124, 65, 67 gives a movement total of 640.
- R5: With mode_i = 1 the grant is the nearest pending cylinder at or beyond the head in the current direction; when none remains the direction flips and the nearest on the other side is granted. From head 53 moving up, the set above is served as 65, 67, 98, 122, 124, 183, 37, 14 with total 299.
- R6: With mode_i = 2 the grant is the nearest pending cylinder at or above the head; when none exists the lowest pending cylinder is granted as a wrap, which adds (MAX−head)+(MAX−target) to the total, MAX being the all-ones cylinder; the direction flag stays 1. The set above from 53 is served as 65, 67, 98, 122, 124, 183, 14, 37 with total 466 for 8-bit cylinders.
- R7: A pending request at the head's own cylinder is granted before any other (in sweep modes) and adds zero movement.
- R8: On done_i with a valid grant, head_o takes the granted cylinder on the next cycle and, outside a wrap, the total grows by the absolute cylinder difference.
- R9: A request pushed while a grant is outstanding competes in the next selection, so in a sweep it is served on the current pass if it lies ahead of the head.
- R10: mode_i = 3 behaves as arrival order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode_i | input | 2 | Policy: 0 arrival order, 1 reversing sweep, 2 one-way sweep, 3 arrival order |
| req_valid_i | input | 1 | Push request valid |
| req_cyl_i | input | CYL_W | Cylinder of the pushed request |
| req_ready_o | output | 1 | Pool can accept a push |
| grant_valid_o | output | 1 | A grant is outstanding |
| grant_cyl_o | output | CYL_W | Cylinder of the outstanding grant |
| done_i | input | 1 | Retire the outstanding grant |
| head_o | output | CYL_W | Current head cylinder |
| dir_up_o | output | 1 | Sweep direction, 1 = upward |
| travel_o | output | TRAV_W | Accumulated head movement |

## Verification
Assertions watch on every cycle that a grant is held steady until done, never exists with an empty pool, that the head lands on the retired cylinder, that a same-cylinder retirement adds nothing, that the movement total never falls, that no push or pop reaches beyond the pool, and that a non-wrapping grant in the one-way mode never lies below the head. Whether the chosen cylinder is the right one for each policy, the exact movement totals, the direction flips and the effect of requests arriving mid-sweep only show up in the bench's scenarios, where a cycle-level reference model predicts every grant.

// File: rtl/dsched_pkg.sv
package dsched_pkg;
    typedef enum logic [1:0] {
        MODE_FIFO  = 2'd0,
        MODE_SWEEP = 2'd1,
        MODE_CIRC  = 2'd2,
        MODE_RSVD  = 2'd3
    } sched_mode_e;
endpackage

// File: rtl/dsched_pool.sv
module dsched_pool #(
    parameter int DEPTH = 8,
    parameter int CYL_W = 8
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            push_i,
    input  logic [CYL_W-1:0]                push_cyl_i,
    input  logic                            pop_i,
    input  logic [$clog2(DEPTH)-1:0]        pop_idx_i,
    output logic [DEPTH-1:0]                valid_o,
    output logic [DEPTH-1:0][CYL_W-1:0]     cyl_o,
    output logic [$clog2(DEPTH+1)-1:0]      count_o
);
    localparam int IDX_W = $clog2(DEPTH);
    localparam int CNT_W = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [DEPTH-1:0][CYL_W-1:0] cyl;
        logic [CNT_W-1:0]            cnt;
    } pool_t;

    pool_t            p_d, p_q;
    logic [CNT_W-1:0] fill;

    // Oldest entry always sits at index 0: removal closes the gap.
    always_comb begin
        p_d  = p_q;
        fill = p_q.cnt;
        if (pop_i) begin
            for (int i = 0; i < DEPTH - 1; i++) begin
                if (IDX_W'(i) >= pop_idx_i) begin
                    p_d.cyl[i] = p_q.cyl[i+1];
                end
            end
            fill = p_q.cnt - CNT_W'(1);
        end
        if (push_i) begin
            for (int i = 0; i < DEPTH; i++) begin
                if (CNT_W'(i) == fill) begin
                    p_d.cyl[i] = push_cyl_i;
                end
            end
            fill = fill + CNT_W'(1);
        end
        p_d.cnt = fill;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) p_q <= '0;
        else        p_q <= p_d;
    end

    for (genvar g = 0; g < DEPTH; g++) begin : g_valid
        assign valid_o[g] = CNT_W'(g) < p_q.cnt;
    end
    assign cyl_o   = p_q.cyl;
    assign count_o = p_q.cnt;

    a_r2_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        push_i |-> (p_q.cnt < CNT_W'(DEPTH)));

    a_r3_pop_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        pop_i |-> (CNT_W'(pop_idx_i) < p_q.cnt));
endmodule

// File: rtl/dsched_pick.sv
module dsched_pick
    import dsched_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int CYL_W = 8
) (
    input  logic [1:0]                      mode_i,
    input  logic [DEPTH-1:0]                valid_i,
    input  logic [DEPTH-1:0][CYL_W-1:0]     cyl_i,
    input  logic [CYL_W-1:0]                head_i,
    input  logic                            dir_up_i,
    output logic                            found_o,
    output logic [$clog2(DEPTH)-1:0]        idx_o,
    output logic [CYL_W-1:0]                cyl_o,
    output logic                            dir_up_o,
    output logic                            wrap_o
);
    localparam int IDX_W = $clog2(DEPTH);

    logic             up_f, dn_f, lo_f;
    logic [IDX_W-1:0] up_i, dn_i, lo_i;
    logic [CYL_W-1:0] up_c, dn_c, lo_c;

    // Nearest at-or-above, nearest at-or-below and lowest overall;
    // strict compares keep the older entry on equal cylinders.
    always_comb begin
        up_f = 1'b0; up_i = '0; up_c = '0;
        dn_f = 1'b0; dn_i = '0; dn_c = '0;
        lo_f = 1'b0; lo_i = '0; lo_c = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (valid_i[i]) begin
                if (cyl_i[i] >= head_i && (!up_f || cyl_i[i] < up_c)) begin
                    up_f = 1'b1; up_i = IDX_W'(i); up_c = cyl_i[i];
                end
                if (cyl_i[i] <= head_i && (!dn_f || cyl_i[i] > dn_c)) begin
                    dn_f = 1'b1; dn_i = IDX_W'(i); dn_c = cyl_i[i];
                end
                if (!lo_f || cyl_i[i] < lo_c) begin
                    lo_f = 1'b1; lo_i = IDX_W'(i); lo_c = cyl_i[i];
                end
            end
        end
    end

    always_comb begin
        found_o  = 1'b0;
        idx_o    = '0;
        cyl_o    = '0;
        dir_up_o = dir_up_i;
        wrap_o   = 1'b0;
        case (sched_mode_e'(mode_i))
            MODE_SWEEP: begin
                if (dir_up_i ? up_f : !dn_f && up_f) begin
                    found_o = 1'b1; idx_o = up_i; cyl_o = up_c; dir_up_o = 1'b1;
                end else if (dn_f) begin
                    found_o = 1'b1; idx_o = dn_i; cyl_o = dn_c; dir_up_o = 1'b0;
                end
            end
            MODE_CIRC: begin
                dir_up_o = 1'b1;
                if (up_f) begin
                    found_o = 1'b1; idx_o = up_i; cyl_o = up_c;
                end else if (lo_f) begin
                    found_o = 1'b1; idx_o = lo_i; cyl_o = lo_c; wrap_o = 1'b1;
                end
            end
            default: begin
                found_o = valid_i[0];
                cyl_o   = cyl_i[0];
            end
        endcase
    end
endmodule

// File: rtl/dsched_dist.sv
module dsched_dist #(
    parameter int CYL_W = 8
) (
    input  logic [CYL_W-1:0] from_i,
    input  logic [CYL_W-1:0] to_i,
    input  logic             wrap_i,
    output logic [CYL_W:0]   dist_o
);
    localparam logic [CYL_W-1:0] CYL_MAX = {CYL_W{1'b1}};

    always_comb begin
        if (wrap_i) begin
            dist_o = {1'b0, CYL_MAX - from_i} + {1'b0, CYL_MAX - to_i};
        end else if (from_i > to_i) begin
            dist_o = {1'b0, from_i - to_i};
        end else begin
            dist_o = {1'b0, to_i - from_i};
        end
    end
endmodule

// File: rtl/disk_elevator_sched.sv
module disk_elevator_sched
    import dsched_pkg::*;
#(
    parameter int DEPTH     = 8,
    parameter int CYL_W     = 8,
    parameter int TRAV_W    = 24,
    parameter int HEAD_INIT = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        mode_i,
    input  logic              req_valid_i,
    input  logic [CYL_W-1:0]  req_cyl_i,
    output logic              req_ready_o,
    output logic              grant_valid_o,
    output logic [CYL_W-1:0]  grant_cyl_o,
    input  logic              done_i,
    output logic [CYL_W-1:0]  head_o,
    output logic              dir_up_o,
    output logic [TRAV_W-1:0] travel_o
);
    localparam int               IDX_W    = $clog2(DEPTH);
    localparam int               CNT_W    = $clog2(DEPTH + 1);
    localparam logic [CYL_W-1:0] HEAD_RST = CYL_W'(HEAD_INIT);

    typedef struct packed {
        logic              gv;
        logic [IDX_W-1:0]  gidx;
        logic [CYL_W-1:0]  gcyl;
        logic              gwrap;
        logic [CYL_W-1:0]  head;
        logic              dir_up;
        logic [TRAV_W-1:0] travel;
    } sched_t;

    sched_t                      st_d, st_q;
    logic [DEPTH-1:0]            pool_valid;
    logic [DEPTH-1:0][CYL_W-1:0] pool_cyl;
    logic [CNT_W-1:0]            pool_cnt;
    logic                        push, retire;
    logic                        pk_found, pk_dir, pk_wrap;
    logic [IDX_W-1:0]            pk_idx;
    logic [CYL_W-1:0]            pk_cyl;
    logic [CYL_W:0]              move;

    assign req_ready_o = pool_cnt < CNT_W'(DEPTH);
    assign push        = req_valid_i & req_ready_o;
    assign retire      = st_q.gv & done_i;

    dsched_pool #(.DEPTH(DEPTH), .CYL_W(CYL_W)) u_pool (
        .clk        (clk),
        .rst_n      (rst_n),
        .push_i     (push),
        .push_cyl_i (req_cyl_i),
        .pop_i      (retire),
        .pop_idx_i  (st_q.gidx),
        .valid_o    (pool_valid),
        .cyl_o      (pool_cyl),
        .count_o    (pool_cnt)
    );

    dsched_pick #(.DEPTH(DEPTH), .CYL_W(CYL_W)) u_pick (
        .mode_i   (mode_i),
        .valid_i  (pool_valid),
        .cyl_i    (pool_cyl),
        .head_i   (st_q.head),
        .dir_up_i (st_q.dir_up),
        .found_o  (pk_found),
        .idx_o    (pk_idx),
        .cyl_o    (pk_cyl),
        .dir_up_o (pk_dir),
        .wrap_o   (pk_wrap)
    );

    dsched_dist #(.CYL_W(CYL_W)) u_dist (
        .from_i (st_q.head),
        .to_i   (st_q.gcyl),
        .wrap_i (st_q.gwrap),
        .dist_o (move)
    );

    always_comb begin
        st_d = st_q;
        if (retire) begin
            st_d.gv     = 1'b0;
            st_d.gwrap  = 1'b0;
            st_d.head   = st_q.gcyl;
            st_d.travel = st_q.travel + TRAV_W'(move);
        end else if (!st_q.gv && pk_found) begin
            st_d.gv     = 1'b1;
            st_d.gidx   = pk_idx;
            st_d.gcyl   = pk_cyl;
            st_d.gwrap  = pk_wrap;
            st_d.dir_up = pk_dir;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q        <= '0;
            st_q.head   <= HEAD_RST;
            st_q.dir_up <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign grant_valid_o = st_q.gv;
    assign grant_cyl_o   = st_q.gcyl;
    assign head_o        = st_q.head;
    assign dir_up_o      = st_q.dir_up;
    assign travel_o      = st_q.travel;

    a_r3_grant_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_valid_o && !done_i) |=> (grant_valid_o && $stable(grant_cyl_o)));

    a_r3_grant_needs_pending: assert property (@(posedge clk) disable iff (!rst_n)
        grant_valid_o |-> (pool_cnt != '0));

    a_r8_head_follows: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_valid_o && done_i) |=> (head_o == $past(grant_cyl_o)));

    a_r8_travel_grows: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (travel_o >= $past(travel_o)));

    a_r7_tie_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_valid_o && done_i && grant_cyl_o == head_o) |=> $stable(travel_o));

    a_r6_circ_upward: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(grant_valid_o) && $past(mode_i) == 2'd2 && !st_q.gwrap)
            |-> (grant_cyl_o >= head_o));
endmodule

// File: tb/disk_elevator_sched_tb.sv
module disk_elevator_sched_tb;
    localparam int DEPTH = 8;
    localparam int CW    = 8;
    localparam int TW    = 24;
    localparam int HI    = 53;
    localparam int CMAX  = 255;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [1:0]    mode_i = 2'd0;
    logic          req_valid_i = 1'b0;
    logic [CW-1:0] req_cyl_i = '0;
    logic          req_ready_o, grant_valid_o, done_i = 1'b0, dir_up_o;
    logic [CW-1:0] grant_cyl_o, head_o;
    logic [TW-1:0] travel_o;

    always #5 clk = ~clk;

    disk_elevator_sched #(.DEPTH(DEPTH), .CYL_W(CW), .TRAV_W(TW), .HEAD_INIT(HI)) u_dut (
        .clk(clk), .rst_n(rst_n), .mode_i(mode_i),
        .req_valid_i(req_valid_i), .req_cyl_i(req_cyl_i), .req_ready_o(req_ready_o),
        .grant_valid_o(grant_valid_o), .grant_cyl_o(grant_cyl_o), .done_i(done_i),
        .head_o(head_o), .dir_up_o(dir_up_o), .travel_o(travel_o)
    );

    int total = 0, bad = 0;
    bit finished = 0;

    // reference model state
    int m_q [DEPTH];
    int m_cnt, m_gv, m_gidx, m_gcyl, m_gwrap, m_head, m_dir, m_trav;
    int p_f, p_idx, p_cyl, p_dir, p_wrap;
    int log_c [16];
    int nlog;

    task automatic chk(string req, int act, int exp, string what);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic string mode_tag(int m);
        if (m == 1) return "R5";
        if (m == 2) return "R6";
        if (m == 3) return "R10";
        return "R4";
    endfunction

    task automatic model_reset();
        m_cnt = 0; m_gv = 0; m_gidx = 0; m_gcyl = 0; m_gwrap = 0;
        m_head = HI; m_dir = 1; m_trav = 0;
    endtask

    task automatic model_pick(int mode);
        int uf, ui, uc, df, di, dc, lf, li, lc;
        uf = 0; ui = 0; uc = 0; df = 0; di = 0; dc = 0; lf = 0; li = 0; lc = 0;
        for (int i = 0; i < m_cnt; i++) begin
            if (m_q[i] >= m_head && (uf == 0 || m_q[i] < uc)) begin uf = 1; ui = i; uc = m_q[i]; end
            if (m_q[i] <= m_head && (df == 0 || m_q[i] > dc)) begin df = 1; di = i; dc = m_q[i]; end
            if (lf == 0 || m_q[i] < lc) begin lf = 1; li = i; lc = m_q[i]; end
        end
        p_f = 0; p_idx = 0; p_cyl = 0; p_dir = m_dir; p_wrap = 0;
        if (mode == 1) begin
            if ((m_dir == 1 && uf == 1) || (m_dir == 0 && df == 0 && uf == 1)) begin
                p_f = 1; p_idx = ui; p_cyl = uc; p_dir = 1;
            end else if (df == 1) begin
                p_f = 1; p_idx = di; p_cyl = dc; p_dir = 0;
            end
        end else if (mode == 2) begin
            p_dir = 1;
            if (uf == 1) begin p_f = 1; p_idx = ui; p_cyl = uc; end
            else if (lf == 1) begin p_f = 1; p_idx = li; p_cyl = lc; p_wrap = 1; end
        end else if (m_cnt > 0) begin
            p_f = 1; p_idx = 0; p_cyl = m_q[0];
        end
    endtask

    task automatic model_edge(int push, int pcyl, int done, int mode);
        int acc;
        acc = (push != 0 && m_cnt < DEPTH) ? 1 : 0;
        model_pick(mode);
        if (done != 0 && m_gv == 1) begin
            for (int i = m_gidx; i < DEPTH - 1; i++) m_q[i] = m_q[i+1];
            m_cnt--;
            if (m_gwrap == 1) m_trav += (CMAX - m_head) + (CMAX - m_gcyl);
            else m_trav += (m_gcyl > m_head) ? m_gcyl - m_head : m_head - m_gcyl;
            m_head = m_gcyl;
            m_gv = 0; m_gwrap = 0;
            if (nlog < 16) log_c[nlog] = m_gcyl;
            nlog++;
        end else if (m_gv == 0 && p_f == 1) begin
            m_gv = 1; m_gidx = p_idx; m_gcyl = p_cyl; m_gwrap = p_wrap; m_dir = p_dir;
        end
        if (acc == 1) begin
            m_q[m_cnt] = pcyl;
            m_cnt++;
        end
    endtask

    // one clock: drive at negedge, model at posedge, compare at next negedge
    task automatic step(int push, int pcyl, int done, int mode);
        req_valid_i = push[0];
        req_cyl_i   = CW'(pcyl);
        done_i      = done[0];
        mode_i      = mode[1:0];
        @(posedge clk);
        model_edge(push, pcyl, done, mode);
        @(negedge clk);
        chk("R2", int'(req_ready_o), (m_cnt < DEPTH) ? 1 : 0, "ready");
        chk("R3", int'(grant_valid_o), m_gv, "grant valid");
        if (m_gv == 1) chk(mode_tag(mode), int'(grant_cyl_o), m_gcyl, "grant cylinder");
        chk("R8", int'(head_o), m_head, "head");
        chk("R8", int'(travel_o), m_trav, "travel");
        chk(mode_tag(mode), int'(dir_up_o), m_dir, "direction");
    endtask

    task automatic do_reset();
        rst_n = 1'b0; req_valid_i = 1'b0; done_i = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        model_reset();
        nlog = 0;
        chk("R1", int'(grant_valid_o), 0, "reset grant");
        chk("R1", int'(req_ready_o), 1, "reset ready");
        chk("R1", int'(head_o), HI, "reset head");
        chk("R1", int'(dir_up_o), 1, "reset dir");
        chk("R1", int'(travel_o), 0, "reset travel");
    endtask

    task automatic serve_all(int mode);
        for (int k = 0; k < 64; k++) begin
            if (m_cnt == 0 && m_gv == 0) break;
            step(0, 0, m_gv, mode);
        end
    endtask

    task automatic wait_grant(int mode);
        for (int k = 0; k < 4; k++) begin
            if (m_gv == 1) break;
            step(0, 0, 0, mode);
        end
    endtask

    int set_a [8] = '{98, 183, 37, 122, 14, 124, 65, 67};
    int set_b [8] = '{65, 98, 183, 37, 122, 14, 124, 67};
    int exp_s [8] = '{65, 67, 98, 122, 124, 183, 37, 14};
    int exp_c [8] = '{65, 67, 98, 122, 124, 183, 14, 37};

    initial begin
        void'($urandom(32'd20240611));
        model_reset();
        nlog = 0;

        // arrival order, plus a dropped push while full (R2, R4)
        do_reset();
        for (int i = 0; i < 8; i++) step(1, set_a[i], 0, 0);
        chk("R2", int'(req_ready_o), 0, "ready low when full");
        step(1, 200, 0, 0);
        serve_all(0);
        chk("R2", nlog, 8, "dropped push not served");
        for (int i = 0; i < 8; i++) chk("R4", log_c[i], set_a[i], "arrival order");
        chk("R4", int'(travel_o), 640, "arrival total");

        // reversing sweep (R5)
        do_reset();
        for (int i = 0; i < 8; i++) step(1, set_b[i], 0, 1);
        serve_all(1);
        for (int i = 0; i < 8; i++) chk("R5", log_c[i], exp_s[i], "sweep order");
        chk("R5", int'(travel_o), 299, "sweep total");

        // one-way sweep with wrap (R6)
        do_reset();
        for (int i = 0; i < 8; i++) step(1, set_b[i], 0, 2);
        serve_all(2);
        for (int i = 0; i < 8; i++) chk("R6", log_c[i], exp_c[i], "circular order");
        chk("R6", int'(travel_o), 466, "circular total");
        chk("R6", int'(dir_up_o), 1, "circular stays up");

        // done without grant is ignored (R3)
        do_reset();
        step(0, 0, 1, 1);
        step(0, 0, 1, 1);
        chk("R3", int'(head_o), HI, "idle done head");
        chk("R3", int'(travel_o), 0, "idle done travel");
        chk("R3", int'(grant_valid_o), 0, "idle done grant");

        // tie at head is served first with zero movement (R7)
        do_reset();
        step(1, 60, 0, 1);
        wait_grant(1);
        step(1, 70, 0, 1);
        step(1, 58, 0, 1);
        step(1, 60, 0, 1);
        step(0, 0, 1, 1);
        wait_grant(1);
        chk("R7", int'(grant_cyl_o), 60, "tie granted");
        chk("R7", int'(travel_o), 7, "travel before tie");
        step(0, 0, 1, 1);
        chk("R7", int'(travel_o), 7, "tie adds zero");
        serve_all(1);

        // mid-sweep arrival ahead of head (R9)
        do_reset();
        step(1, 65, 0, 1);
        wait_grant(1);
        step(1, 40, 0, 1);
        step(1, 100, 0, 1);
        serve_all(1);
        chk("R9", log_c[0], 65, "first");
        chk("R9", log_c[1], 100, "ahead served on pass");
        chk("R9", log_c[2], 40, "behind served after turn");

        // reserved mode acts as arrival order (R10)
        do_reset();
        step(1, 98, 0, 3);
        step(1, 37, 0, 3);
        step(1, 140, 0, 3);
        serve_all(3);
        chk("R10", log_c[0], 98, "mode 3 first");
        chk("R10", log_c[1], 37, "mode 3 second");
        chk("R10", log_c[2], 140, "mode 3 third");

        // constrained random against the model (R2 R3 R4 R5 R6 R8)
        do_reset();
        begin
            int mode;
            mode = 1;
            for (int c = 0; c < 4000; c++) begin
                if (c % 250 == 0) mode = int'($urandom_range(0, 3));
                step(($urandom_range(0, 2) == 0) ? 1 : 0,
                     int'($urandom_range(0, CMAX)),
                     ($urandom_range(0, 2) == 0) ? 1 : 0,
                     mode);
            end
        end

        if (!finished) begin
            finished = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        #2000000;
        if (!finished) begin
            finished = 1;
            total++;
            bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule